// File: doc/BRIEF.md
# Self-Timed Page Programming Controller

This block sits behind the serial bus engine of a byte-wide non-volatile memory. When the engine has taken in a complete page burst and seen the terminating stop, it pulses a commit strobe. With that strobe it hands over a 10-bit base address, a byte count and up to sixteen data bytes. The controller latches the burst and runs one self-timed programming interval of fixed length. It raises `busy` for that whole interval, and the engine uses `busy` to withhold acknowledges from the host. At the end of the interval it streams the staged bytes into a synchronous array through a simple write port.

Two conditions block a rewrite: a write-protect input and a low-supply flag. The write-protect input also works as a cancel, but only inside a window. The window opens when the engine reports the clock edge that captured the last bit of the first data byte. It stays open through the programming phase of the cycle. Before that point write-protect is a don't-care. A cancelled or inhibited write releases `busy` at once and never reaches the array.

The interval length is the parameter `CYCLE_LEN`, counted in clock cycles. Its default gives 5 ms at 250 MHz, and a bench can use a short value. Bytes are stored only in the last `PAGE_BYTES` cycles of the interval, so the total busy time does not depend on the byte count.

Top module: `wcyc_ctrl`

## Requirements
- R1: A commit that is accepted raises `busy` in the cycle after the commit and holds it for exactly `CYCLE_LEN` cycles, for any byte count from 1 to 16. A commit is accepted when the block is idle, `byte_count` is non-zero, `wp` and `low_vcc` are low, and no window cancel is pending.
- R2: Staged byte i is stored at the address whose upper 6 bits equal those of `base_addr` and whose low 4 bits equal (`base_addr[3:0]` + i) mod 16, for i below the count. No other location changes. Byte i is taken from `burst_data[8*i+7:8*i]`.
- R3: `wp` driven high while the cancel window is closed, that is before `first_bit_seen` in the current transaction, has no effect on the following commit.
- R4: `wp` high in the cycle `first_bit_seen` is asserted, or in any later cycle up to the commit, makes that commit refused: `busy` stays low and the array is unchanged. The commit clears the pending cancel, so the next clean transaction is accepted.
- R5: A commit that arrives while `wp` or `low_vcc` is high is refused: `busy` stays low and the array is unchanged.
- R6: `wp` or `low_vcc` high in any of the first `CYCLE_LEN`-16 busy cycles (the programming phase), including the last one, drops `busy` in the next cycle and leaves the array unchanged.
- R7: During the final 16 busy cycles (the store phase), `wp` and `low_vcc` are ignored. The full burst is stored and `busy` lasts its full length.
- R8: A commit while `busy` is high is ignored, and so is a commit with a byte count of 0. A byte count from 17 to 31 is treated as 16.
- R9: While reset is held, and in the first cycle after it, `busy` and `arr_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| commit | input | 1 | One-cycle strobe from the engine: burst complete, start the cycle |
| base_addr | input | 10 | Byte address of the first data byte |
| byte_count | input | 5 | Number of staged bytes (0 to 31, values above 16 are clamped) |
| burst_data | input | 128 | Staged bytes, byte i in bits 8i+7..8i |
| first_bit_seen | input | 1 | Strobe: the edge that captured bit 0 of the first data byte has occurred |
| wp | input | 1 | Write protect, high blocks or cancels a rewrite |
| low_vcc | input | 1 | Supply below the rewrite threshold |
| busy | output | 1 | Programming interval in progress |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | 10 | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The sharpest collision is a cancel that lands on the last programming cycle, the same cycle in which the timer would move the block into the store phase. The bench raises `wp` there and expects the abort to win: `busy` ends after `CYCLE_LEN`-16 cycles and memory is untouched. One cycle later, in the store phase, the same stimulus must instead give a full-length interval and a complete store. A second collision is `wp` rising in the very cycle the window opens, and it must count as a cancel. In both cases the verdict comes from the measured busy length and from a full compare of the array against a bench-side image.

// File: rtl/wcyc_pkg.sv
// Shared types for the self-timed page programming controller.
package wcyc_pkg;

    // Controller phases: idle, timed programming, byte store.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_STORE = 2'd2
    } wc_state_e;

endpackage

// File: rtl/wcyc_window.sv
// Write-protect cancel window.
// Opens on the strobe marking capture of bit 0 of the first data byte and
// latches a cancel if wp is high from that cycle on. A commit closes the
// window and clears any latched cancel. Assumes one strobe per transaction.
module wcyc_window (
    input  logic clk,
    input  logic rst_n,
    input  logic open_strobe,
    input  logic wp,
    input  logic commit,
    output logic veto
);

    logic armed;

    // Track the window and latch a cancel seen inside it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            veto  <= 1'b0;
        end else if (commit) begin
            armed <= 1'b0;
            veto  <= 1'b0;
        end else begin
            if (open_strobe)
                armed <= 1'b1;
            if ((armed || open_strobe) && wp)
                veto <= 1'b1;
        end
    end

    assert_prewindow_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !open_strobe && !veto) |=> !veto);

    assert_commit_clears_cancel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (!veto && !armed));

endmodule

// File: rtl/wcyc_timer.sv
// Programming interval counter.
// Counts cycles while the controller is active. It flags the last cycle of
// the programming phase and the last cycle of the whole interval.
// Assumes CYCLE_LEN > PAGE_BYTES.
module wcyc_timer #(
    parameter int CYCLE_LEN  = 1250000,
    parameter int PAGE_BYTES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    input  logic active,
    output logic prog_done,
    output logic cycle_done
);

    localparam int TMR_W    = $clog2(CYCLE_LEN);
    localparam int PROG_LEN = CYCLE_LEN - PAGE_BYTES;

    logic [TMR_W-1:0] cnt;

    // Cycle counter, restarted on start or abort, wraps at interval end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start || abort)
            cnt <= '0;
        else if (active)
            cnt <= cycle_done ? '0 : cnt + 1'b1;
    end

    // Phase boundary flags.
    always_comb begin
        prog_done  = active && (cnt == TMR_W'(PROG_LEN - 1));
        cycle_done = active && (cnt == TMR_W'(CYCLE_LEN - 1));
    end

    assert_interval_runs_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> $past(active));

endmodule

// File: rtl/wcyc_stage.sv
// Burst staging and array write sequencer.
// Latches base, clamped count and data on load. During the store phase it
// emits one array write per cycle for the staged bytes. The low address bits
// wrap within the page.
module wcyc_stage #(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic                         store,
    input  logic [ADDR_W-1:0]            base_in,
    input  logic [$clog2(PAGE_BYTES):0]  count_in,
    input  logic [PAGE_BYTES*DATA_W-1:0] data_in,
    output logic                         arr_we,
    output logic [ADDR_W-1:0]            arr_addr,
    output logic [DATA_W-1:0]            arr_wdata
);

    localparam int PAGE_BITS = $clog2(PAGE_BYTES);
    localparam int CNT_W     = PAGE_BITS + 1;

    logic [ADDR_W-1:0]            base_q;
    logic [CNT_W-1:0]             cnt_q;
    logic [PAGE_BYTES*DATA_W-1:0] data_q;
    logic [PAGE_BITS-1:0]         idx;

    // Capture the burst on load and step the byte index while storing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            data_q <= '0;
            idx    <= '0;
        end else if (load) begin
            base_q <= base_in;
            cnt_q  <= (count_in > CNT_W'(PAGE_BYTES)) ? CNT_W'(PAGE_BYTES) : count_in;
            data_q <= data_in;
            idx    <= '0;
        end else if (store) begin
            idx <= idx + 1'b1;
        end
    end

    // Array write port: mask bytes beyond the count, wrap within the page.
    always_comb begin
        arr_we    = store && ({1'b0, idx} < cnt_q);
        arr_addr  = {base_q[ADDR_W-1:PAGE_BITS], base_q[PAGE_BITS-1:0] + idx};
        arr_wdata = data_q[idx*DATA_W +: DATA_W];
    end

    assert_page_wrap_increment_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |->
            (arr_addr[PAGE_BITS-1:0] == PAGE_BITS'($past(arr_addr[PAGE_BITS-1:0]) + 1'b1)));

    assert_burst_held_while_storing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (store && $past(store)) |-> ($stable(base_q) && $stable(cnt_q)));

endmodule

// File: rtl/wcyc_ctrl.sv
// Self-timed page programming controller, top level.
// Accepts a committed burst, runs a fixed-length programming interval with
// busy high, and stores the burst in the last PAGE_BYTES cycles. Write
// protect and low supply refuse a commit, and they abort the interval during
// its programming phase. Assumes the engine drives commit only after stop.
module wcyc_ctrl
    import wcyc_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16,
    parameter int CYCLE_LEN  = 1250000
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                commit,
    input  logic [ADDR_W-1:0]                   base_addr,
    input  logic [$clog2(PAGE_BYTES):0]         byte_count,
    input  logic [PAGE_BYTES*DATA_W-1:0]        burst_data,
    input  logic                                first_bit_seen,
    input  logic                                wp,
    input  logic                                low_vcc,
    output logic                                busy,
    output logic                                arr_we,
    output logic [ADDR_W-1:0]                   arr_addr,
    output logic [DATA_W-1:0]                   arr_wdata
);

    wc_state_e state;
    logic      veto;
    logic      accept;
    logic      abort;
    logic      prog_done;
    logic      cycle_done;

    // Acceptance of a commit and abort of a running programming phase.
    always_comb begin
        accept = commit && (state == ST_IDLE) && (byte_count != '0)
                 && !wp && !low_vcc && !veto;
        abort  = (state == ST_PROG) && (wp || low_vcc);
        busy   = (state != ST_IDLE);
    end

    // Phase sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE:  if (accept) state <= ST_PROG;
                ST_PROG:  if (abort) state <= ST_IDLE;
                          else if (prog_done) state <= ST_STORE;
                ST_STORE: if (cycle_done) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    wcyc_window u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .open_strobe (first_bit_seen),
        .wp          (wp),
        .commit      (commit),
        .veto        (veto)
    );

    wcyc_timer #(
        .CYCLE_LEN  (CYCLE_LEN),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .abort      (abort),
        .active     (busy),
        .prog_done  (prog_done),
        .cycle_done (cycle_done)
    );

    wcyc_stage #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .store     (state == ST_STORE),
        .base_in   (base_addr),
        .count_in  (byte_count),
        .data_in   (burst_data),
        .arr_we    (arr_we),
        .arr_addr  (arr_addr),
        .arr_wdata (arr_wdata)
    );

    assert_busy_needs_commit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(commit));

    assert_refused_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && commit && (wp || low_vcc)) |=> !busy);

    assert_abort_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy);

    assert_store_phase_atomic_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STORE && !cycle_done) |=> (state == ST_STORE));

    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |=> (!busy && !arr_we));

endmodule

// File: tb/wcyc_ctrl_bench.sv
// Self-checking bench: sweeps byte counts and page offsets, then the window,
// inhibit, abort, store-phase and ignored-commit corners.
module wcyc_ctrl_bench;

    localparam int AW = 10;
    localparam int DW = 8;
    localparam int PB = 16;
    localparam int CL = 40;
    localparam int PL = CL - PB;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              commit = 1'b0;
    logic [AW-1:0]     base_addr = '0;
    logic [4:0]        byte_count = '0;
    logic [PB*DW-1:0]  burst_data = '0;
    logic              first_bit_seen = 1'b0;
    logic              wp = 1'b0;
    logic              low_vcc = 1'b0;
    logic              busy;
    logic              arr_we;
    logic [AW-1:0]     arr_addr;
    logic [DW-1:0]     arr_wdata;

    logic [7:0] mem  [1024];
    logic [7:0] expm [1024];

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    wcyc_ctrl #(
        .ADDR_W (AW), .DATA_W (DW), .PAGE_BYTES (PB), .CYCLE_LEN (CL)
    ) u_wcyc_ctrl (
        .clk (clk), .rst_n (rst_n), .commit (commit), .base_addr (base_addr),
        .byte_count (byte_count), .burst_data (burst_data),
        .first_bit_seen (first_bit_seen), .wp (wp), .low_vcc (low_vcc),
        .busy (busy), .arr_we (arr_we), .arr_addr (arr_addr), .arr_wdata (arr_wdata)
    );

    // Array model behind the write port.
    always @(posedge clk) if (arr_we) mem[arr_addr] <= arr_wdata;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 13 + i * 29 + 7) & 255);
    endfunction

    task automatic load_burst(input int base, input int cnt, input int seed);
        base_addr  = AW'(base);
        byte_count = 5'(cnt);
        for (int i = 0; i < PB; i++) burst_data[i*DW +: DW] = pat(seed, i);
    endtask

    task automatic exp_write(input int base, input int cnt, input int seed);
        int n;
        n = (cnt > PB) ? PB : cnt;
        for (int i = 0; i < n; i++)
            expm[(base & 10'h3F0) | ((base + i) & 15)] = pat(seed, i);
    endtask

    task automatic check_mem(input string tag);
        int mm;
        mm = 0;
        for (int a = 0; a < 1024; a++) if (mem[a] !== expm[a]) mm++;
        check(mm == 0, tag, mm, 0);
    endtask

    task automatic strobe();
        first_bit_seen = 1'b1;
        @(negedge clk);
        first_bit_seen = 1'b0;
    endtask

    task automatic pulse_commit();
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    // Count busy cycles. At busy sample k apply: 1=wp, 2=low_vcc, 3=commit.
    task automatic run_busy(input int k, input int mode, output int n);
        n = 0;
        while (busy && n < CL + 10) begin
            if (n == k) begin
                if (mode == 1) wp = 1'b1;
                if (mode == 2) low_vcc = 1'b1;
                if (mode == 3) begin load_burst(10'h0C3, 9, 99); commit = 1'b1; end
            end
            if (n == k + 1) commit = 1'b0;
            n++;
            @(negedge clk);
        end
        wp = 1'b0; low_vcc = 1'b0; commit = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int n;
        int seed;
        int bases [4];
        bases = '{10'h000, 10'h00E, 10'h3F7, 10'h155};
        for (int a = 0; a < 1024; a++) begin mem[a] = 8'hFF; expm[a] = 8'hFF; end
        seed = 1;

        repeat (3) @(negedge clk);
        check(busy == 1'b0 && arr_we == 1'b0, "R9 reset quiet", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R9 after reset", int'(busy), 0);

        // R1/R2 sweep: every count at several page offsets, including wrap.
        for (int b = 0; b < 4; b++) begin
            for (int c = 1; c <= PB; c++) begin
                seed++;
                load_burst(bases[b], c, seed);
                strobe();
                pulse_commit();
                run_busy(-5, 0, n);
                check(n == CL, "R1 busy length", n, CL);
                exp_write(bases[b], c, seed);
                check_mem("R2 stored bytes");
            end
        end

        // R8: count above a page clamps to 16.
        seed++;
        load_burst(10'h2A9, 20, seed); strobe(); pulse_commit();
        run_busy(-5, 0, n);
        check(n == CL, "R8 clamp busy", n, CL);
        exp_write(10'h2A9, 20, seed);
        check_mem("R8 clamp stores 16");

        // R8: zero count ignored.
        load_burst(10'h100, 0, 77); strobe(); pulse_commit();
        check(busy == 1'b0, "R8 zero count", int'(busy), 0);
        check_mem("R8 zero count array");

        // R3: wp pulse before the window opens.
        seed++;
        load_burst(10'h0A2, 5, seed);
        wp = 1'b1; @(negedge clk); wp = 1'b0; @(negedge clk);
        strobe(); pulse_commit();
        run_busy(-5, 0, n);
        check(n == CL, "R3 early wp ignored busy", n, CL);
        exp_write(10'h0A2, 5, seed);
        check_mem("R3 early wp ignored array");

        // R4: wp inside the window, after the strobe.
        load_burst(10'h1B0, 4, 55);
        strobe();
        wp = 1'b1; @(negedge clk); wp = 1'b0; @(negedge clk);
        pulse_commit();
        check(busy == 1'b0, "R4 window cancel", int'(busy), 0);
        check_mem("R4 window cancel array");

        // R4: wp in the same cycle the window opens.
        load_burst(10'h1B0, 4, 56);
        wp = 1'b1; strobe(); wp = 1'b0;
        pulse_commit();
        check(busy == 1'b0, "R4 cancel on open edge", int'(busy), 0);
        check_mem("R4 open edge array");

        // R4: cancel cleared by the commit, clean transaction accepted.
        seed++;
        load_burst(10'h1B0, 4, seed); strobe(); pulse_commit();
        run_busy(-5, 0, n);
        check(n == CL, "R4 next accepted", n, CL);
        exp_write(10'h1B0, 4, seed);
        check_mem("R4 next accepted array");

        // R5: wp or low supply at commit.
        load_burst(10'h222, 3, 60); strobe();
        wp = 1'b1; pulse_commit(); wp = 1'b0;
        check(busy == 1'b0, "R5 wp at commit", int'(busy), 0);
        load_burst(10'h222, 3, 61); strobe();
        low_vcc = 1'b1; pulse_commit(); low_vcc = 1'b0;
        check(busy == 1'b0, "R5 low supply at commit", int'(busy), 0);
        check_mem("R5 array unchanged");

        // R6: aborts during programming, including its last cycle.
        load_burst(10'h333, 8, 70); strobe(); pulse_commit();
        run_busy(0, 1, n);
        check(n == 1, "R6 wp abort first cycle", n, 1);
        load_burst(10'h333, 8, 71); strobe(); pulse_commit();
        run_busy(5, 2, n);
        check(n == 6, "R6 low supply abort", n, 6);
        load_burst(10'h333, 8, 72); strobe(); pulse_commit();
        run_busy(PL - 1, 1, n);
        check(n == PL, "R6 abort last prog cycle", n, PL);
        check_mem("R6 array unchanged");

        // R7: wp and low supply during store are ignored.
        seed++;
        load_burst(10'h3FC, 16, seed); strobe(); pulse_commit();
        run_busy(PL, 1, n);
        check(n == CL, "R7 wp in store", n, CL);
        exp_write(10'h3FC, 16, seed);
        check_mem("R7 wp in store array");
        seed++;
        load_burst(10'h045, 7, seed); strobe(); pulse_commit();
        run_busy(PL + 3, 2, n);
        check(n == CL, "R7 low supply in store", n, CL);
        exp_write(10'h045, 7, seed);
        check_mem("R7 low supply array");

        // R8: commit while busy ignored.
        seed++;
        load_burst(10'h280, 6, seed); strobe(); pulse_commit();
        run_busy(10, 3, n);
        check(n == CL, "R8 busy commit length", n, CL);
        exp_write(10'h280, 6, seed);
        check_mem("R8 busy commit array");
        check(busy == 1'b0, "R8 no second cycle", int'(busy), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule